// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts a 32-bit virtual address into one of five fixed windows and decides, from the current privilege mode, what happens to the access. Two kernel-only windows translate straight to a physical address by dropping the top three address bits. The lowest window and the two highest windows need a page-table lookup, which the block flags with a "mapped" output for the translation unit that follows. An access that the current mode may not make is reported as an address error, split into a load or a store kind by the write flag.

An error-level status input makes the lowest window bypass translation: while it is set, any address below 0x80000000 passes through unchanged as the physical address, for reads and writes alike. The outputs can be produced in the same cycle as the inputs, or through one output register that also carries a valid strobe, selected by a parameter.

Top module: `vaddr_seg_decode`

## Requirements
- R1: With the error-level input low, an address in 0x00000000..0x7FFFFFFF gives mapped=1, bad_addr=0, exc=00 and paddr=0 in every mode.
- R2: With the error-level input high, an address in 0x00000000..0x7FFFFFFF gives mapped=0, bad_addr=0, exc=00 and paddr equal to the address, in every mode, for reads and writes.
- R3: An address in 0x80000000..0x9FFFFFFF in kernel mode gives paddr = address - 0x80000000, mapped=0, bad_addr=0.
- R4: An address in 0xA0000000..0xBFFFFFFF in kernel mode gives paddr = address - 0xA0000000, mapped=0, bad_addr=0.
- R5: An address in 0xC0000000..0xDFFFFFFF gives mapped=1 and no error in supervisor or kernel mode, and an address error in user mode.
- R6: An address in 0xE0000000..0xFFFFFFFF gives mapped=1 and no error in kernel mode, and an address error in supervisor and user mode.
- R7: An address error drives bad_addr=1, mapped=0, paddr=0 and exc=10 when is_write is 1 (store) or exc=01 when is_write is 0 (load); without an error exc=00 and bad_addr=0.
- R8: The mode input codes are 00 kernel, 01 supervisor, 10 user, and 11 is treated as user; kernel-only windows (0x80000000..0xBFFFFFFF) are address errors in supervisor and user mode.
- R9: The error-level input has no effect on addresses at or above 0x80000000.
- R10: With REG_OUT=1 the outputs appear one clock after the inputs and out_valid is in_valid delayed by one clock; reset clears out_valid and all outputs. With REG_OUT=0 the outputs and out_valid follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input address is valid |
| vaddr | input | 32 | Virtual address |
| mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 1x user |
| is_write | input | 1 | 1 for a store, 0 for a load |
| err_lvl | input | 1 | Error-level status bit |
| out_valid | output | 1 | Outputs are valid |
| paddr | output | 32 | Physical address for directly mapped results |
| mapped | output | 1 | Address needs page-table translation |
| bad_addr | output | 1 | Access is an address error |
| exc | output | 2 | 00 none, 01 load address error, 10 store address error |

## Verification
The bench aims at the window edges (0x7FFFFFFF/0x80000000, 0x9FFFFFFF/0xA0000000, 0xBFFFFFFF/0xC0000000, 0xDFFFFFFF/0xE0000000, 0xFFFFFFFF), where a wrong comparison would put an address in the neighbouring window and change its offset or its access rule. It crosses every window with all four mode codes, so a design that treated code 11 as kernel, or let supervisor into the top window, reports a mapped access instead of an error. The error-level bit is driven with upper-half addresses too, where a design that leaked it would pass the address through unchanged, and the load/store flag is swapped on every error to catch a reversed exception code. Both the registered and the same-cycle variants are checked, so a missing or extra stage shows as stale results.

// File: rtl/vaddr_seg_decode.sv
module vaddr_seg_decode #(
  parameter int AW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] vaddr,
  input  logic [1:0]    mode,
  input  logic          is_write,
  input  logic          err_lvl,
  output logic          out_valid,
  output logic [AW-1:0] paddr,
  output logic          mapped,
  output logic          bad_addr,
  output logic [1:0]    exc
);
  localparam int OFS_W = AW - 3;
  localparam logic [1:0] EXC_NONE = 2'b00;
  localparam logic [1:0] EXC_LOAD = 2'b01;
  localparam logic [1:0] EXC_STORE = 2'b10;

  logic          kern, sup;
  logic [2:0]    win;
  logic          allowed, direct;
  logic [AW-1:0] pa_raw;
  logic [AW-1:0] c_pa;
  logic          c_map, c_bad;
  logic [1:0]    c_exc;

  assign kern = (mode == 2'b00);
  assign sup  = (mode == 2'b01);
  assign win  = vaddr[AW-1 -: 3];

  always_comb begin
    allowed = 1'b0;
    direct  = 1'b0;
    pa_raw  = vaddr;
    case (win)
      3'b100, 3'b101: begin
        allowed = kern;
        direct  = 1'b1;
        pa_raw  = {3'b000, vaddr[OFS_W-1:0]};
      end
      3'b110: allowed = kern | sup;
      3'b111: allowed = kern;
      default: begin
        allowed = 1'b1;
        direct  = err_lvl;
      end
    endcase
  end

  assign c_bad = ~allowed;
  assign c_map = allowed & ~direct;
  assign c_pa  = (allowed & direct) ? pa_raw : '0;
  assign c_exc = allowed ? EXC_NONE : (is_write ? EXC_STORE : EXC_LOAD);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          paddr     <= '0;
          mapped    <= 1'b0;
          bad_addr  <= 1'b0;
          exc       <= EXC_NONE;
        end else begin
          out_valid <= in_valid;
          paddr     <= c_pa;
          mapped    <= c_map;
          bad_addr  <= c_bad;
          exc       <= c_exc;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign paddr     = c_pa;
      assign mapped    = c_map;
      assign bad_addr  = c_bad;
      assign exc       = c_exc;
    end
  endgenerate
endmodule

module vaddr_seg_decode_chk #(
  parameter int AW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [AW-1:0] vaddr,
  input logic [1:0]    mode,
  input logic          is_write,
  input logic          err_lvl,
  input logic          out_valid,
  input logic [AW-1:0] paddr,
  input logic          mapped,
  input logic          bad_addr,
  input logic [1:0]    exc
);
  assert_err_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> (!mapped && paddr == '0 && exc != 2'b00));
  assert_map_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mapped |-> (!bad_addr && exc == 2'b00 && paddr == '0));
  assert_exc_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc != 2'b11);

  generate
    if (REG_OUT) begin : g_reg
      assert_valid_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      assert_valid_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      assert_user_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && vaddr[AW-1]) |=> bad_addr);
      assert_store_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_write && mode[1] && vaddr[AW-1]) |=> exc == 2'b10);
      assert_erl_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && err_lvl && !vaddr[AW-1]) |=> (!mapped && !bad_addr && paddr == $past(vaddr)));
    end else begin : g_comb
      assert_valid_same_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      assert_user_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && vaddr[AW-1]) |-> bad_addr);
      assert_store_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_write && mode[1] && vaddr[AW-1]) |-> exc == 2'b10);
      assert_erl_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lvl && !vaddr[AW-1]) |-> (!mapped && !bad_addr && paddr == vaddr));
    end
  endgenerate
endmodule

bind vaddr_seg_decode vaddr_seg_decode_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr), .mode(mode),
  .is_write(is_write), .err_lvl(err_lvl), .out_valid(out_valid), .paddr(paddr),
  .mapped(mapped), .bad_addr(bad_addr), .exc(exc)
);

// File: tb/tb_vaddr_seg_decode.sv
`timescale 1ns/1ps
module tb_vaddr_seg_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  mode = '0;
  logic        is_write = 1'b0;
  logic        err_lvl = 1'b0;

  logic        ov_r, map_r, bad_r, ov_c, map_c, bad_c;
  logic [31:0] pa_r, pa_c;
  logic [1:0]  exc_r, exc_c;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vaddr_seg_decode #(.AW(32), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr), .mode(mode),
    .is_write(is_write), .err_lvl(err_lvl), .out_valid(ov_r), .paddr(pa_r),
    .mapped(map_r), .bad_addr(bad_r), .exc(exc_r));

  vaddr_seg_decode #(.AW(32), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vaddr(vaddr), .mode(mode),
    .is_write(is_write), .err_lvl(err_lvl), .out_valid(ov_c), .paddr(pa_c),
    .mapped(map_c), .bad_addr(bad_c), .exc(exc_c));

  // expected value packed as {paddr, mapped, bad, exc}
  function automatic logic [35:0] model(input logic [31:0] a, input logic [1:0] m,
                                        input logic w, input logic e);
    logic k, s, ok;
    k = (m == 2'b00);
    s = (m == 2'b01);
    if (a < 32'h8000_0000) begin
      if (e) return {a, 1'b0, 1'b0, 2'b00};
      return {32'h0, 1'b1, 1'b0, 2'b00};
    end
    if (a < 32'hA000_0000) ok = k;
    else if (a < 32'hC000_0000) ok = k;
    else if (a < 32'hE000_0000) ok = k | s;
    else ok = k;
    if (!ok) return {32'h0, 1'b0, 1'b1, (w ? 2'b10 : 2'b01)};
    if (a < 32'hA000_0000) return {a - 32'h8000_0000, 1'b0, 1'b0, 2'b00};
    if (a < 32'hC000_0000) return {a - 32'hA000_0000, 1'b0, 1'b0, 2'b00};
    return {32'h0, 1'b1, 1'b0, 2'b00};
  endfunction

  function automatic string tag(input logic [31:0] a, input logic [1:0] m, input logic e);
    logic [35:0] x;
    x = model(a, m, 1'b0, e);
    if (x[2]) return (m[1] ? "R8/R7" : "R6/R7");
    if (a < 32'h8000_0000) return (e ? "R2" : "R1");
    if (e) return "R9";
    if (a < 32'hA000_0000) return "R3";
    if (a < 32'hC000_0000) return "R4";
    if (a < 32'hE000_0000) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got pa=%h map=%b bad=%b exc=%b expected pa=%h map=%b bad=%b exc=%b",
               req, act[35:4], act[3], act[2], act[1:0], exp[35:4], exp[3], exp[2], exp[1:0]);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] m, input logic w, input logic e);
    logic [35:0] exp;
    string t;
    exp = model(a, m, w, e);
    t = tag(a, m, e);
    @(negedge clk);
    in_valid = 1'b1; vaddr = a; mode = m; is_write = w; err_lvl = e;
    #1;
    check({t, " comb"}, {pa_c, map_c, bad_c, exc_c}, exp);
    check("R10 comb valid", {35'h0, ov_c}, 36'h1);
    @(posedge clk);
    #1;
    check({t, " reg"}, {pa_r, map_r, bad_r, exc_r}, exp);
    check("R10 reg valid", {35'h0, ov_r}, 36'h1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] edges [10];
    void'($urandom(32'h1234_5678));
    edges = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000,
              32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};
    in_valid = 1'b1;
    vaddr = 32'h8000_1234;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset", {pa_r, map_r, bad_r, exc_r}, 36'h0);
    check("R10 reset valid", {35'h0, ov_r}, 36'h0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          apply(edges[i], m[1:0], m[0] ^ e[0], e[0]);
    for (int n = 0; n < 600; n++)
      apply($urandom, 2'($urandom), 1'($urandom), 1'($urandom));
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R10 comb idle", {35'h0, ov_c}, 36'h0);
    @(posedge clk);
    #1;
    check("R10 reg idle", {35'h0, ov_r}, 36'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule